// File: doc/BRIEF.md
# Legacy Prefix Scanner

This block sits at the front of an instruction decode path. It takes one instruction byte per cycle over a valid/ready handshake. It gathers the legacy prefix bytes in front of an instruction and stops at the first byte that is not a prefix. At that point it holds a summary until the consumer takes it. The summary gives the lock flag, the repeat kind, the segment override, the branch hint, the resolved operand and address sizes, the number of prefix bytes, and the opcode byte for the opcode decoder downstream. If the opcode is the two-byte escape 0x0F, the scanner also takes the byte after it. That byte is needed to recognise conditional jumps in the escaped range.

Prefixes may arrive in any order. When two bytes fall in the same group, the later one takes effect. The two size-override bytes toggle the size given by the `def32` input. The bytes 0x2E and 0x3E have two meanings. In front of a conditional jump they are reported as branch hints. In front of any other opcode they are reported as segment overrides. A run of prefixes that is too long is dropped, and an error pulse is raised.

Top module: `pfx_scan`

## Requirements
- R1: On a non-jump opcode, the last segment byte is reported on `out_seg` with this coding: 0x26→1, 0x2E→2, 0x36→3, 0x3E→4, 0x64→5, 0x65→6. Code 0 means no override.
- R2: 0xF0 sets `out_lock`. `out_rep` reports the repeat kind: 1 for 0xF3, 2 for 0xF2, 0 for none. When both repeat bytes appear, the later one wins.
- R3: When several segment bytes precede the opcode, only the last one is reported.
- R4: A conditional jump is an opcode in 0x70–0x7F, or 0x0F followed by a byte in 0x80–0x8F. Before a conditional jump, a last segment byte of 0x2E gives `out_hint`=1 (not taken) and 0x3E gives `out_hint`=2 (taken). In both cases `out_seg`=0. Any other segment byte before a jump is still reported as a segment, with `out_hint`=0.
- R5: `out_op32` is `def32` inverted if at least one 0x66 byte was seen. `out_adr32` is `def32` inverted if at least one 0x67 byte was seen. Repeated override bytes do not toggle the size again.
- R6: `out_rep_na` is 1 when a repeat prefix is present and the opcode is neither a string opcode nor a port opcode. String opcodes are 0xA4–0xA7, 0xAA–0xAF and 0x6C–0x6F. Port opcodes are 0xE4–0xE7 and 0xEC–0xEF. Any two-byte opcode counts as not applicable.
- R7: `out_count` gives the number of prefix bytes accepted for the instruction, with duplicates counted.
- R8: If a prefix byte arrives while MAX_PFX (14) prefixes are already held, `err` pulses for one cycle in the cycle after that byte. All prefix state is then dropped, and the next byte starts a fresh instruction.
- R9: `out_valid` rises in the cycle after the opcode byte is taken, or after the second byte of an escaped opcode. It stays high with every field stable until `out_ready` is seen. While it is high, `in_ready` is low. After the handshake, all prefix state is clear.
- R10: For opcode 0x0F, one more byte is consumed. The result shows `out_two`=1, `out_opcode`=0x0F and `out_opcode2` equal to that byte.
- R11: After reset, `out_valid`=0, `in_ready`=1, `err`=0 and `out_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| def32 | input | 1 | Default size of the current segment (1 = 32-bit) |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Scanner accepts a byte |
| out_valid | output | 1 | Summary valid |
| out_ready | input | 1 | Consumer takes the summary |
| out_lock | output | 1 | Lock prefix seen |
| out_rep | output | 2 | Repeat kind |
| out_rep_na | output | 1 | Repeat prefix not applicable to the opcode |
| out_seg | output | 3 | Segment override code |
| out_hint | output | 2 | Branch hint code |
| out_op32 | output | 1 | Effective operand size is 32 bits |
| out_adr32 | output | 1 | Effective address size is 32 bits |
| out_count | output | CNT_W (4) | Prefix byte count |
| out_two | output | 1 | Escaped two-byte opcode |
| out_opcode | output | 8 | Opcode byte |
| out_opcode2 | output | 8 | Second opcode byte (valid when out_two) |
| err | output | 1 | Prefix run overflow pulse |

## Verification
The assertions rely on three things about the inputs. `def32` stays constant while an instruction is in flight. `in_byte` holds steady while `in_valid` is high. `out_ready` is only useful while a summary is held. The bench changes `def32` only between instructions, once the previous summary has been taken. It drives inputs on the falling edge. It lowers `in_valid` during every hold period, so no byte is presented while the scanner refuses input.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ESC_BYTE = 8'h0F;

  typedef enum logic [2:0] {
    SEG_NONE = 3'd0, SEG_ES = 3'd1, SEG_CS = 3'd2, SEG_SS = 3'd3,
    SEG_DS = 3'd4, SEG_FS = 3'd5, SEG_GS = 3'd6
  } seg_e;

  typedef enum logic [1:0] {REP_NONE = 2'd0, REP_E = 2'd1, REP_NE = 2'd2} rep_e;
  typedef enum logic [1:0] {HINT_NONE = 2'd0, HINT_NT = 2'd1, HINT_T = 2'd2} hint_e;

  typedef struct packed {
    logic is_pfx;
    logic lock;
    rep_e rep;
    seg_e seg;
    logic op_ovr;
    logic ad_ovr;
  } pclass_t;

  // Opcodes on which a repeat prefix has meaning: string moves and port transfers
  function automatic logic rep_applies(input logic [BYTE_W-1:0] b);
    return (b inside {[8'hA4:8'hA7], [8'hAA:8'hAF], [8'h6C:8'h6F],
                      [8'hE4:8'hE7], [8'hEC:8'hEF]});
  endfunction
endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output pclass_t           cls_o
);
  always_comb begin
    cls_o = '{is_pfx: 1'b1, lock: 1'b0, rep: REP_NONE, seg: SEG_NONE,
              op_ovr: 1'b0, ad_ovr: 1'b0};
    case (byte_i)
      8'hF0: cls_o.lock   = 1'b1;
      8'hF3: cls_o.rep    = REP_E;
      8'hF2: cls_o.rep    = REP_NE;
      8'h26: cls_o.seg    = SEG_ES;
      8'h2E: cls_o.seg    = SEG_CS;
      8'h36: cls_o.seg    = SEG_SS;
      8'h3E: cls_o.seg    = SEG_DS;
      8'h64: cls_o.seg    = SEG_FS;
      8'h65: cls_o.seg    = SEG_GS;
      8'h66: cls_o.op_ovr = 1'b1;
      8'h67: cls_o.ad_ovr = 1'b1;
      default: cls_o.is_pfx = 1'b0;
    endcase
  end
endmodule

// File: rtl/pfx_accum.sv
module pfx_accum
  import pfx_pkg::*;
#(
  parameter int MAX_PFX = 14,
  parameter int CNT_W   = $clog2(MAX_PFX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             clr_i,
  input  pclass_t          cls_i,
  output logic             lock_o,
  output rep_e             rep_o,
  output seg_e             seg_o,
  output logic             op_ovr_o,
  output logic             ad_ovr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PFX);

  logic             lock_q, lock_d;
  rep_e             rep_q, rep_d;
  seg_e             seg_q, seg_d;
  logic             op_q, op_d, ad_q, ad_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  assign upd_en = take_i | clr_i;

  always_comb begin
    lock_d = lock_q;
    rep_d  = rep_q;
    seg_d  = seg_q;
    op_d   = op_q;
    ad_d   = ad_q;
    cnt_d  = cnt_q;
    if (clr_i) begin
      lock_d = 1'b0;
      rep_d  = REP_NONE;
      seg_d  = SEG_NONE;
      op_d   = 1'b0;
      ad_d   = 1'b0;
      cnt_d  = '0;
    end else if (take_i) begin
      lock_d = lock_q | cls_i.lock;
      if (cls_i.rep != REP_NONE) rep_d = cls_i.rep;
      if (cls_i.seg != SEG_NONE) seg_d = cls_i.seg;
      op_d  = op_q | cls_i.op_ovr;
      ad_d  = ad_q | cls_i.ad_ovr;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      rep_q  <= REP_NONE;
      seg_q  <= SEG_NONE;
      op_q   <= 1'b0;
      ad_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      lock_q <= lock_d;
      rep_q  <= rep_d;
      seg_q  <= seg_d;
      op_q   <= op_d;
      ad_q   <= ad_d;
      cnt_q  <= cnt_d;
    end
  end

  assign lock_o   = lock_q;
  assign rep_o    = rep_q;
  assign seg_o    = seg_q;
  assign op_ovr_o = op_q;
  assign ad_ovr_o = ad_q;
  assign cnt_o    = cnt_q;
  assign full_o   = (cnt_q == CNT_MAX);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX); // R7
  AST_TAKE_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> !full_o); // R8
endmodule

// File: rtl/pfx_resolve.sv
module pfx_resolve
  import pfx_pkg::*;
(
  input  logic              def32_i,
  input  logic              two_i,
  input  logic [BYTE_W-1:0] op_i,
  input  logic [BYTE_W-1:0] op2_i,
  input  rep_e              rep_i,
  input  seg_e              seg_i,
  input  logic              op_ovr_i,
  input  logic              ad_ovr_i,
  output seg_e              seg_o,
  output hint_e             hint_o,
  output logic              rep_na_o,
  output logic              op32_o,
  output logic              ad32_o
);
  logic is_jcc;

  assign is_jcc = two_i ? (op2_i[7:4] == 4'h8) : (op_i[7:4] == 4'h7);

  always_comb begin
    seg_o  = seg_i;
    hint_o = HINT_NONE;
    if (is_jcc && seg_i == SEG_CS) begin
      seg_o  = SEG_NONE;
      hint_o = HINT_NT;
    end else if (is_jcc && seg_i == SEG_DS) begin
      seg_o  = SEG_NONE;
      hint_o = HINT_T;
    end
  end

  assign rep_na_o = (rep_i != REP_NONE) && (two_i || !rep_applies(op_i));
  assign op32_o   = def32_i ^ op_ovr_i;
  assign ad32_o   = def32_i ^ ad_ovr_i;
endmodule

// File: rtl/pfx_scan.sv
module pfx_scan
  import pfx_pkg::*;
#(
  parameter int MAX_PFX = 14,
  parameter int CNT_W   = $clog2(MAX_PFX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             def32,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_lock,
  output logic [1:0]       out_rep,
  output logic             out_rep_na,
  output logic [2:0]       out_seg,
  output logic [1:0]       out_hint,
  output logic             out_op32,
  output logic             out_adr32,
  output logic [CNT_W-1:0] out_count,
  output logic             out_two,
  output logic [7:0]       out_opcode,
  output logic [7:0]       out_opcode2,
  output logic             err
);
  typedef enum logic [1:0] {ST_SCAN, ST_ESC, ST_HOLD} st_e;

  st_e               st_q, st_d;
  logic [BYTE_W-1:0] op_q, op_d, op2_q, op2_d;
  logic              two_q, two_d, err_q, err_d;
  logic              op_en, op2_en;
  logic              take, ovf, ack;
  pclass_t           cls;
  logic              a_lock, a_op, a_ad, a_full;
  rep_e              a_rep;
  seg_e              a_seg, r_seg;
  hint_e             r_hint;
  logic [CNT_W-1:0]  a_cnt;

  pfx_classify u_cls (.byte_i(in_byte), .cls_o(cls));

  pfx_accum #(.MAX_PFX(MAX_PFX), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .take_i(take), .clr_i(ovf | ack), .cls_i(cls),
    .lock_o(a_lock), .rep_o(a_rep), .seg_o(a_seg), .op_ovr_o(a_op),
    .ad_ovr_o(a_ad), .cnt_o(a_cnt), .full_o(a_full)
  );

  pfx_resolve u_res (
    .def32_i(def32), .two_i(two_q), .op_i(op_q), .op2_i(op2_q),
    .rep_i(a_rep), .seg_i(a_seg), .op_ovr_i(a_op), .ad_ovr_i(a_ad),
    .seg_o(r_seg), .hint_o(r_hint), .rep_na_o(out_rep_na),
    .op32_o(out_op32), .ad32_o(out_adr32)
  );

  // Next-state process
  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    op2_d  = op2_q;
    two_d  = two_q;
    op_en  = 1'b0;
    op2_en = 1'b0;
    take   = 1'b0;
    ovf    = 1'b0;
    ack    = 1'b0;
    case (st_q)
      ST_SCAN: if (in_valid) begin
        if (cls.is_pfx) begin
          if (a_full) ovf = 1'b1;
          else        take = 1'b1;
        end else begin
          op_en  = 1'b1;
          op2_en = 1'b1;
          op_d   = in_byte;
          two_d  = (in_byte == ESC_BYTE);
          op2_d  = '0;
          st_d   = (in_byte == ESC_BYTE) ? ST_ESC : ST_HOLD;
        end
      end
      ST_ESC: if (in_valid) begin
        op2_en = 1'b1;
        op2_d  = in_byte;
        st_d   = ST_HOLD;
      end
      ST_HOLD: if (out_ready) begin
        ack  = 1'b1;
        st_d = ST_SCAN;
      end
      default: st_d = ST_SCAN;
    endcase
    err_d = ovf;
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SCAN;
      err_q <= 1'b0;
      op_q  <= '0;
      two_q <= 1'b0;
      op2_q <= '0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      if (op_en) begin
        op_q  <= op_d;
        two_q <= two_d;
      end
      if (op2_en) op2_q <= op2_d;
    end
  end

  assign in_ready    = (st_q != ST_HOLD);
  assign out_valid   = (st_q == ST_HOLD);
  assign out_lock    = a_lock;
  assign out_rep     = a_rep;
  assign out_seg     = r_seg;
  assign out_hint    = r_hint;
  assign out_count   = a_cnt;
  assign out_two     = two_q;
  assign out_opcode  = op_q;
  assign out_opcode2 = op2_q;
  assign err         = err_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode)
      && $stable(out_seg) && $stable(out_count)); // R9
  AST_NO_INPUT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R9
  AST_CLEAR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> out_count == '0 && !out_valid); // R9
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err); // R8
  AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid && out_count == '0); // R8
  AST_HINT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hint != 2'd0 |-> out_seg == 3'd0); // R4
  AST_REPNA_NEEDS_REP: assert property (@(posedge clk) disable iff (!rst_n)
    out_rep_na |-> out_rep != 2'd0); // R6
endmodule

// File: tb/pfx_scan_bench.sv
module pfx_scan_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic def32 = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_lock, out_rep_na, out_op32, out_adr32, out_two, err;
  logic [1:0] out_rep, out_hint;
  logic [2:0] out_seg;
  logic [3:0] out_count;
  logic [7:0] out_opcode, out_opcode2;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pfx_scan u_pfx_scan (
    .clk(clk), .rst_n(rst_n), .def32(def32), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_lock(out_lock), .out_rep(out_rep), .out_rep_na(out_rep_na), .out_seg(out_seg),
    .out_hint(out_hint), .out_op32(out_op32), .out_adr32(out_adr32),
    .out_count(out_count), .out_two(out_two), .out_opcode(out_opcode),
    .out_opcode2(out_opcode2), .err(err)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
  endtask

  task automatic stop_in();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic ack();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  // Checks the held summary, then completes the handshake
  task automatic expect_out(input string tag, input logic lk, input logic [1:0] rp,
                            input logic na, input logic [2:0] sg, input logic [1:0] hn,
                            input logic o32, input logic a32, input int cnt,
                            input logic [7:0] op);
    chk(out_valid == 1'b1, {tag, " valid"}, out_valid, 1);
    chk(out_lock == lk, {tag, " lock"}, out_lock, lk);
    chk(out_rep == rp, {tag, " rep"}, out_rep, rp);
    chk(out_rep_na == na, {tag, " rep_na"}, out_rep_na, na);
    chk(out_seg == sg, {tag, " seg"}, out_seg, sg);
    chk(out_hint == hn, {tag, " hint"}, out_hint, hn);
    chk(out_op32 == o32, {tag, " op32"}, out_op32, o32);
    chk(out_adr32 == a32, {tag, " adr32"}, out_adr32, a32);
    chk(out_count == 4'(cnt), {tag, " count"}, out_count, cnt);
    chk(out_opcode == op, {tag, " opcode"}, out_opcode, op);
    ack();
  endtask

  task automatic t_reset();
    chk(out_valid == 0, "R11 out_valid", out_valid, 0);
    chk(in_ready == 1, "R11 in_ready", in_ready, 1);
    chk(err == 0, "R11 err", err, 0);
    chk(out_count == 0, "R11 count", out_count, 0);
  endtask

  task automatic t_segments();
    send(8'h26); send(8'h90); stop_in();
    expect_out("R1 ES", 0, 0, 0, 3'd1, 0, 1, 1, 1, 8'h90);
    send(8'h65); send(8'h8B); stop_in();
    expect_out("R1 GS", 0, 0, 0, 3'd6, 0, 1, 1, 1, 8'h8B);
    send(8'h2E); send(8'h90); stop_in();
    expect_out("R1 CS not jump", 0, 0, 0, 3'd2, 0, 1, 1, 1, 8'h90);
  endtask

  task automatic t_lock_rep();
    send(8'hF0); send(8'hF3); send(8'hA5); stop_in();
    expect_out("R2 lock rep", 1, 2'd1, 0, 0, 0, 1, 1, 2, 8'hA5);
    send(8'hF3); send(8'hF2); send(8'hA4); stop_in();
    expect_out("R2 last rep", 0, 2'd2, 0, 0, 0, 1, 1, 2, 8'hA4);
    send(8'hF3); send(8'hEC); stop_in();
    expect_out("R6 port ok", 0, 2'd1, 0, 0, 0, 1, 1, 1, 8'hEC);
    send(8'hF3); send(8'h90); stop_in();
    expect_out("R6 rep_na", 0, 2'd1, 1, 0, 0, 1, 1, 1, 8'h90);
  endtask

  task automatic t_last_seg();
    send(8'h26); send(8'h36); send(8'h64); send(8'h8B); stop_in();
    expect_out("R3 R7 last seg", 0, 0, 0, 3'd5, 0, 1, 1, 3, 8'h8B);
  endtask

  task automatic t_hints();
    send(8'h3E); send(8'h74); stop_in();
    expect_out("R4 taken", 0, 0, 0, 0, 2'd2, 1, 1, 1, 8'h74);
    send(8'h65); send(8'h75); stop_in();
    expect_out("R4 other seg", 0, 0, 0, 3'd6, 0, 1, 1, 1, 8'h75);
    send(8'hF3); send(8'h2E); send(8'h0F);
    @(negedge clk);
    chk(out_valid == 0, "R10 wait second byte", out_valid, 0);
    in_byte = 8'h85;
    @(posedge clk);
    stop_in();
    chk(out_two == 1, "R10 two", out_two, 1);
    chk(out_opcode2 == 8'h85, "R10 opcode2", out_opcode2, 8'h85);
    expect_out("R4 R10 not taken", 0, 2'd1, 1, 0, 2'd1, 1, 1, 2, 8'h0F);
  endtask

  task automatic t_sizes();
    def32 = 1'b1;
    send(8'h66); send(8'h89); stop_in();
    expect_out("R5 def32", 0, 0, 0, 0, 0, 0, 1, 1, 8'h89);
    def32 = 1'b0;
    send(8'h66); send(8'h67); send(8'h67); send(8'h89); stop_in();
    expect_out("R5 def16", 0, 0, 0, 0, 0, 1, 1, 3, 8'h89);
    def32 = 1'b1;
  endtask

  task automatic t_hold();
    send(8'h64); send(8'h90); stop_in();
    for (int i = 0; i < 3; i++) begin
      chk(out_valid == 1, "R9 held valid", out_valid, 1);
      chk(in_ready == 0, "R9 in_ready low", in_ready, 0);
      chk(out_seg == 3'd5, "R9 held seg", out_seg, 5);
      @(negedge clk);
    end
    ack();
    chk(out_valid == 0, "R9 released", out_valid, 0);
    chk(out_count == 0, "R9 cleared", out_count, 0);
    send(8'h90); stop_in();
    expect_out("R9 fresh", 0, 0, 0, 0, 0, 1, 1, 0, 8'h90);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 15; i++) send(8'h66);
    stop_in();
    chk(err == 1, "R8 err pulse", err, 1);
    chk(out_valid == 0, "R8 no summary", out_valid, 0);
    @(negedge clk);
    chk(err == 0, "R8 err one cycle", err, 0);
    send(8'h90); stop_in();
    expect_out("R8 discarded", 0, 0, 0, 0, 0, 1, 1, 0, 8'h90);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_segments();
    t_lock_rep();
    t_last_seg();
    t_hints();
    t_sizes();
    t_hold();
    t_overflow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule